// File: doc/BRIEF.md
# Dual Seconds Counter Core

This block keeps two 32-bit seconds counts that share one seconds tick. The tick comes from a prescaler that divides the reference clock, nominally 32.768 kHz, and runs on that clock. A 3-bit trim value changes the prescaler's terminal count. Larger trim values give a faster tick and smaller values give a slower one. A trim of zero stops the timebase.

The run counter advances on every tick. The powered-time counter advances only on ticks that arrive while the supply-valid input is high, so it records how long the supply has been present.

A serial front end sits next to this block and drives it through single-cycle pulses. It uses them to write the trim value, to clear either counter or both, and to load a counter with a 32-bit value. Both counts are visible at the outputs at all times.

Top module: `sec_counter_core`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both counts read zero and the trim register holds 3.
- R2: At trim 3 the tick goes high for one cycle every REF_HZ reference cycles. The run counter adds one on each tick.
- R3: The powered-time counter adds one only on a tick cycle with `supply_ok_i` high. It holds its value on every other cycle.
- R4: A pulse on `trim_we_i` captures `trim_i`. For a nonzero trim t, the tick period is REF_HZ - (t - 3) * TRIM_STEP reference cycles.
- R5: With trim 0 the tick never fires and neither counter changes, except through a clear or a load.
- R6: `clr_run_i` sets the run count to zero and `clr_pwr_i` sets the powered-time count to zero. Both may be pulsed in the same cycle.
- R7: `load_run_i` or `load_pwr_i` replaces all 32 bits of that counter with `load_data_i` in one cycle.
- R8: On any one counter, a clear wins over a load, and a load wins over a tick increment in the same cycle.
- R9: A counter at 0xFFFFFFFF goes to 0 on its next increment.
- R10: If a trim write leaves the prescaler phase at or above the new terminal count, the tick fires on the next cycle and the phase then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 32.768 kHz) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trim_i | input | 3 | New trim value |
| trim_we_i | input | 1 | Write pulse for the trim register |
| supply_ok_i | input | 1 | Supply-valid; gates the powered-time counter |
| clr_run_i | input | 1 | Clear pulse for the run counter |
| clr_pwr_i | input | 1 | Clear pulse for the powered-time counter |
| load_run_i | input | 1 | Load pulse for the run counter |
| load_pwr_i | input | 1 | Load pulse for the powered-time counter |
| load_data_i | input | 32 | Parallel load value |
| run_count_o | output | 32 | Run counter value |
| pwr_count_o | output | 32 | Powered-time counter value |
| tick_o | output | 1 | One-cycle seconds tick |

## Verification
Some rules can be checked on every cycle, and the assertions cover them. They are:
- the zero state after reset;
- the step of one per tick, including the wrap;
- holding when there is no tick or the supply is low;
- the clear result;
- the load result;
- the order in which clear, load and tick win.

Other behaviour needs time to show, and only the bench's scenarios can reveal it. That covers the tick period at each trim value, the stopped timebase at trim 0, and the early tick after a trim write shortens the period. The bench covers these with a cycle model, using a reduced REF_HZ so that many periods fit in one run.

// File: rtl/sec_pkg.sv
package sec_pkg;
  // Nominal trim code: tick period equals REF_HZ cycles at this value.
  localparam int unsigned TRIM_NOMINAL = 3;

  // Per-counter control bundle.
  typedef struct packed {
    logic clr;
    logic load;
    logic gate;
  } cnt_ctl_t;

  // Terminal phase value for a given nonzero trim code.
  function automatic int term_count(input int ref_hz, input int step, input int trim);
    return ref_hz - 1 - (trim - int'(TRIM_NOMINAL)) * step;
  endfunction
endpackage

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
  parameter int unsigned REF_HZ    = 32768,
  parameter int unsigned TRIM_STEP = 4,
  parameter int unsigned TRIM_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              trim_we_i,
  output logic              tick_o
);
  import sec_pkg::*;

  // Longest period occurs at trim 1.
  localparam int unsigned MAX_PERIOD = REF_HZ + (TRIM_NOMINAL - 1) * TRIM_STEP;
  localparam int unsigned DIV_W      = $clog2(MAX_PERIOD);

  logic [TRIM_W-1:0] trim_q, trim_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [DIV_W-1:0]  limit;
  logic              run_en;

  always_comb begin
    limit  = DIV_W'(term_count(int'(REF_HZ), int'(TRIM_STEP), int'(trim_q)));
    run_en = (trim_q != '0);
    tick_o = run_en && (div_q >= limit);
  end

  always_comb begin
    trim_d = trim_we_i ? trim_i : trim_q;
    if (!run_en)     div_d = div_q;
    else if (tick_o) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= TRIM_W'(TRIM_NOMINAL);
      div_q  <= '0;
    end else begin
      trim_q <= trim_d;
      div_q  <= div_d;
    end
  end
endmodule

// File: rtl/sec_counter.sv
module sec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  sec_pkg::cnt_ctl_t ctl_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = ctl_i.clr | ctl_i.load | (tick_i & ctl_i.gate);
    if (ctl_i.clr)       cnt_d = '0;
    else if (ctl_i.load) cnt_d = data_i;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/sec_counter_core.sv
module sec_counter_core #(
  parameter int unsigned REF_HZ    = 32768,
  parameter int unsigned TRIM_STEP = 4,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned TRIM_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              trim_we_i,
  input  logic              supply_ok_i,
  input  logic              clr_run_i,
  input  logic              clr_pwr_i,
  input  logic              load_run_i,
  input  logic              load_pwr_i,
  input  logic [CNT_W-1:0]  load_data_i,
  output logic [CNT_W-1:0]  run_count_o,
  output logic [CNT_W-1:0]  pwr_count_o,
  output logic              tick_o
);
  import sec_pkg::*;

  localparam int unsigned N_CNT = 2;

  logic             tick;
  cnt_ctl_t         ctl   [N_CNT];
  logic [CNT_W-1:0] count [N_CNT];

  sec_prescaler #(
    .REF_HZ   (REF_HZ),
    .TRIM_STEP(TRIM_STEP),
    .TRIM_W   (TRIM_W)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .trim_i   (trim_i),
    .trim_we_i(trim_we_i),
    .tick_o   (tick)
  );

  // Index 0: run counter (always gated on); index 1: powered-time counter.
  always_comb begin
    ctl[0] = '{clr: clr_run_i, load: load_run_i, gate: 1'b1};
    ctl[1] = '{clr: clr_pwr_i, load: load_pwr_i, gate: supply_ok_i};
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    sec_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .ctl_i  (ctl[g]),
      .data_i (load_data_i),
      .count_o(count[g])
    );
  end

  assign run_count_o = count[0];
  assign pwr_count_o = count[1];
  assign tick_o      = tick;
endmodule

// File: rtl/sec_counter_core_chk.sv
module sec_counter_core_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok_i,
  input logic             clr_run_i,
  input logic             clr_pwr_i,
  input logic             load_run_i,
  input logic             load_pwr_i,
  input logic [CNT_W-1:0] load_data_i,
  input logic [CNT_W-1:0] run_count_o,
  input logic [CNT_W-1:0] pwr_count_o,
  input logic             tick_o
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (run_count_o == '0 && pwr_count_o == '0));

  // R2 and R9: one step per tick, wrapping modulo 2**CNT_W
  p_run_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !clr_run_i && !load_run_i) |=> run_count_o == $past(run_count_o) + 1'b1);

  p_pwr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && supply_ok_i && !clr_pwr_i && !load_pwr_i)
      |=> pwr_count_o == $past(pwr_count_o) + 1'b1);

  p_pwr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok_i && !clr_pwr_i && !load_pwr_i) |=> $stable(pwr_count_o));

  p_run_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_o && !clr_run_i && !load_run_i) |=> $stable(run_count_o));

  p_clear_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_run_i |=> run_count_o == '0);

  p_clear_pwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pwr_i |=> pwr_count_o == '0);

  // R7 and R8: a load without a clear overrides any tick
  p_load_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_run_i && !clr_run_i) |=> run_count_o == $past(load_data_i));

  p_load_pwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pwr_i && !clr_pwr_i) |=> pwr_count_o == $past(load_data_i));
endmodule

bind sec_counter_core sec_counter_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_ok_i(supply_ok_i),
  .clr_run_i  (clr_run_i),
  .clr_pwr_i  (clr_pwr_i),
  .load_run_i (load_run_i),
  .load_pwr_i (load_pwr_i),
  .load_data_i(load_data_i),
  .run_count_o(run_count_o),
  .pwr_count_o(pwr_count_o),
  .tick_o     (tick_o)
);

// File: tb/sec_counter_core_tb.sv
module sec_counter_core_tb;
  localparam int REF  = 16;
  localparam int STEP = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  trim_i;
  logic        trim_we_i, supply_ok_i, clr_run_i, clr_pwr_i, load_run_i, load_pwr_i;
  logic [31:0] load_data_i, run_count_o, pwr_count_o;
  logic        tick_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sec_counter_core #(.REF_HZ(REF), .TRIM_STEP(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .trim_i(trim_i), .trim_we_i(trim_we_i),
    .supply_ok_i(supply_ok_i), .clr_run_i(clr_run_i), .clr_pwr_i(clr_pwr_i),
    .load_run_i(load_run_i), .load_pwr_i(load_pwr_i), .load_data_i(load_data_i),
    .run_count_o(run_count_o), .pwr_count_o(pwr_count_o), .tick_o(tick_o)
  );

  // Reference model built from the requirements.
  int          m_trim, m_div;
  logic [31:0] m_run, m_pwr;

  function automatic int period(input int t);
    return REF - (t - 3) * STEP;
  endfunction

  function automatic bit m_tick();
    return (m_trim != 0) && (m_div >= period(m_trim) - 1);
  endfunction

  function automatic logic [31:0] next_cnt(input logic [31:0] c, input bit clr,
                                           input bit ld, input bit adv);
    if (clr) return 32'd0;
    if (ld)  return load_data_i;
    if (adv) return c + 32'd1;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_trim = 3; m_div = 0; m_run = 0; m_pwr = 0;
    end else begin
      bit t;
      t = m_tick();
      m_run = next_cnt(m_run, clr_run_i, load_run_i, t);
      m_pwr = next_cnt(m_pwr, clr_pwr_i, load_pwr_i, t && supply_ok_i);
      if (m_trim != 0) m_div = t ? 0 : m_div + 1;
      if (trim_we_i) m_trim = int'(trim_i);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    chk(run_count_o == m_run, {req, " run"}, run_count_o, m_run);
    chk(pwr_count_o == m_pwr, {req, " pwr"}, pwr_count_o, m_pwr);
    chk(tick_o == m_tick(), {req, " tick"}, 32'(tick_o), 32'(m_tick()));
  endtask

  task automatic idle();
    trim_we_i = 0; clr_run_i = 0; clr_pwr_i = 0; load_run_i = 0; load_pwr_i = 0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_trim(input int t);
    trim_i = 3'(t); trim_we_i = 1; @(negedge clk); trim_we_i = 0;
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 64 && !tick_o; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; idle(); trim_i = 3; supply_ok_i = 1; load_data_i = 0;
    cycles(3);
    chk(run_count_o == 0 && pwr_count_o == 0, "R1 reset counts", run_count_o, 0);
    rst_n = 1;
    @(negedge clk);
    cmp_all("R1");

    // R2: nominal period, 3 ticks in 3*REF cycles from reset release
    cycles(3 * REF - 1);
    chk(run_count_o == 3, "R2 three seconds", run_count_o, 3);
    cmp_all("R2");

    // R3: supply low holds powered-time counter
    supply_ok_i = 0;
    cycles(2 * REF);
    chk(pwr_count_o == 3, "R3 hold while supply low", pwr_count_o, 3);
    cmp_all("R3");
    supply_ok_i = 1;

    // R4: fast and slow trims
    set_trim(7);
    cycles(3 * period(7)); cmp_all("R4 trim7");
    set_trim(1);
    cycles(3 * period(1)); cmp_all("R4 trim1");

    // R10: shorten period while phase is past the new terminal count
    wait_tick(); cycles(16);
    trim_i = 3'd7; trim_we_i = 1; @(negedge clk); trim_we_i = 0;
    chk(tick_o == 1, "R10 early tick", 32'(tick_o), 1);
    cmp_all("R10");

    // R5: trim zero stops everything
    set_trim(0);
    begin
      logic [31:0] r0;
      r0 = run_count_o;
      cycles(100);
      chk(run_count_o == r0, "R5 stopped", run_count_o, r0);
      chk(tick_o == 0, "R5 no tick", 32'(tick_o), 0);
    end
    cmp_all("R5");
    set_trim(3);

    // R6: clear both at once
    clr_run_i = 1; clr_pwr_i = 1; @(negedge clk); idle();
    chk(run_count_o == 0 && pwr_count_o == 0, "R6 clear both", run_count_o | pwr_count_o, 0);

    // R7: load each counter
    load_data_i = 32'h1234_5678; load_run_i = 1; @(negedge clk); idle();
    chk(run_count_o == 32'h1234_5678, "R7 load run", run_count_o, 32'h1234_5678);
    load_data_i = 32'hA5A5_0F0F; load_pwr_i = 1; @(negedge clk); idle();
    chk(pwr_count_o == 32'hA5A5_0F0F, "R7 load pwr", pwr_count_o, 32'hA5A5_0F0F);

    // R8: load on a tick cycle, then clear plus load
    wait_tick();
    load_data_i = 32'h0000_0100; load_run_i = 1; @(negedge clk); idle();
    chk(run_count_o == 32'h100, "R8 load beats tick", run_count_o, 32'h100);
    clr_pwr_i = 1; load_pwr_i = 1; @(negedge clk); idle();
    chk(pwr_count_o == 0, "R8 clear beats load", pwr_count_o, 0);

    // R9: wrap
    wait_tick(); @(negedge clk);
    load_data_i = 32'hFFFF_FFFF; load_run_i = 1; load_pwr_i = 1; @(negedge clk); idle();
    wait_tick(); @(negedge clk);
    chk(run_count_o == 0, "R9 wrap run", run_count_o, 0);
    chk(pwr_count_o == 0, "R9 wrap pwr", pwr_count_o, 0);

    // Random phase against the model
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      trim_we_i   = ($urandom % 150) == 0;
      trim_i      = 3'($urandom % 8);
      if (($urandom % 30) == 0) supply_ok_i = ~supply_ok_i;
      clr_run_i   = ($urandom % 60) == 0;
      clr_pwr_i   = ($urandom % 60) == 0;
      load_run_i  = ($urandom % 50) == 0;
      load_pwr_i  = ($urandom % 50) == 0;
      load_data_i = (($urandom % 4) == 0) ? 32'hFFFF_FFFE : $urandom;
      @(negedge clk);
      cmp_all("R2-random R3 R4 R6 R7 R8");
    end
    idle();
    finish_run();
  end
endmodule